// File: doc/BRIEF.md
# CAN Receive Queue with Release Pacing

This block manages the receive side of a CAN controller. A receive engine hands over complete frames through a one-cycle push strobe. The block keeps them in a small in-order queue and always shows the oldest held frame to the CPU. Frames that come back from the controller's own transmit side arrive through the same push strobe.

After the CPU has read the head frame, it gives a release command. The next queued frame then appears at once. The receive interrupt stays low for a fixed number of cycles after each accepted release before it may rise again.

A frame pushed while the queue is full is dropped, and a sticky overrun flag is raised. The overrun interrupt pulses only when the flag goes from clear to set, so further drops stay silent until the CPU clears the flag with its own command. Frame decoding, acceptance filtering and the bus protocol are handled elsewhere.

Top module: `can_rxq_release`

## Requirements
- R1: Frames are held in arrival order, up to DEPTH (default 2). `head_frame` shows the oldest held frame and reads all zeros when the queue is empty. `head_frame` does not change while frames are held and no release is given.
- R2: `rbuf_avail` is high exactly while at least one frame is held. It rises at the clock edge that accepts a push into an empty queue.
- R3: A release given while frames are held removes the head frame. From that same edge, `head_frame` shows the next frame, or zeros if none is left.
- R4: A release given while the queue is empty changes nothing: `rbuf_avail`, `head_frame`, `rx_irq` and the overrun outputs keep their values, and no pacing delay is started.
- R5: `rx_irq` is high only while a frame is held. When no pacing delay is running, it rises one edge after `rbuf_avail` rises.
- R6: At the edge of an accepted release, `rx_irq` goes low. It stays low for the next GAP edges (default 2). At the (GAP+1)-th edge after the release it rises if a frame is still held.
- R7: A push while the queue is full and no release is given drops that frame. `ovr_status` is set at that edge, and the queued frames are not changed.
- R8: A push and a release in the same cycle on a full queue both take effect: the head is removed, the new frame is stored at the tail, and no overrun is flagged.
- R9: `clr_ovr_cmd` clears `ovr_status` at the next edge. If an overrun happens in the same cycle, the flag stays set.
- R10: `ovr_irq` is a one-cycle pulse that comes with a clear-to-set change of `ovr_status`. No pulse occurs for overruns while the flag is already set.
- R11: While reset is asserted, and right after it, all outputs are zero. `rst_n` clears the block asynchronously, and its release takes effect through a two-stage synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_push | input | 1 | One-cycle strobe: a new frame from the receive engine |
| rx_frame | input | DATA_W | Frame contents that come with `rx_push` |
| rel_cmd | input | 1 | Release command for the head frame |
| clr_ovr_cmd | input | 1 | Clear command for the overrun flag |
| head_frame | output | DATA_W | Oldest held frame, zero when empty |
| rbuf_avail | output | 1 | At least one frame is held |
| ovr_status | output | 1 | Sticky overrun flag |
| rx_irq | output | 1 | Receive interrupt, paced after release |
| ovr_irq | output | 1 | One-cycle overrun interrupt pulse |

## Verification
Queue contents, `rbuf_avail`, `head_frame` and `ovr_status` all update at the edge that samples the command. `rx_irq` follows one edge later, or GAP+1 edges after an accepted release, and `ovr_irq` pulses at the same edge that sets the flag. The bench drives each command for exactly one cycle, starting at a falling edge. It samples at the following falling edge and then steps idle cycles one at a time. This lets it check the interrupt in every cycle of the pacing window: low on the release cycle and on the GAP cycles after it, high on the next one.

// File: rtl/can_rxq_pkg.sv
package can_rxq_pkg;

  // Per-cycle queue events that the overrun tracker consumes
  typedef struct packed {
    logic accept;  // frame stored
    logic pop;     // head frame removed
    logic drop;    // frame discarded because the queue was full
  } rxq_evt_t;

endpackage

// File: rtl/can_rxq_rst_sync.sv
module can_rxq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_q_n = sync_q[1];

endmodule

// File: rtl/can_rxq_store.sv
module can_rxq_store
  import can_rxq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              pop_req_i,
  output logic [DATA_W-1:0] head_o,
  output logic              avail_o,
  output rxq_evt_t          evt_o
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] slot_q [DEPTH];
  logic [PW-1:0]     rd_q, rd_d, wr_q, wr_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic              full, empty, pop, accept, drop;

  always_comb begin
    full   = (cnt_q == CW'(DEPTH));
    empty  = (cnt_q == '0);
    pop    = pop_req_i && !empty;
    accept = push_i && (!full || pop);
    drop   = push_i && full && !pop;

    cnt_d = cnt_q;
    if (accept && !pop)      cnt_d = cnt_q + 1'b1;
    else if (pop && !accept) cnt_d = cnt_q - 1'b1;

    rd_d = rd_q;
    if (pop) rd_d = (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;

    wr_d = wr_q;
    if (accept) wr_d = (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rd_q  <= '0;
      wr_q  <= '0;
    end else begin
      cnt_q <= cnt_d;
      rd_q  <= rd_d;
      wr_q  <= wr_d;
    end
  end

  // Payload storage carries no reset; the head is gated by occupancy.
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (accept && (wr_q == PW'(i))) slot_q[i] <= data_i;
    end
  end

  assign avail_o = !empty;
  assign head_o  = empty ? '0 : slot_q[rd_q];
  assign evt_o   = '{accept: accept, pop: pop, drop: drop};

endmodule

// File: rtl/can_rxq_irq_pacer.sv
module can_rxq_irq_pacer #(
  parameter int GAP = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pop_i,
  input  logic avail_i,
  output logic irq_o
);

  localparam int HW = $clog2(GAP + 2);

  logic [HW-1:0] hold_q, hold_d;
  logic          irq_q, irq_d;

  always_comb begin
    hold_d = hold_q;
    irq_d  = irq_q;
    if (pop_i) begin
      hold_d = HW'(GAP);
      irq_d  = 1'b0;
    end else if (hold_q != '0) begin
      hold_d = hold_q - 1'b1;
      irq_d  = 1'b0;
    end else begin
      irq_d  = avail_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      hold_q <= hold_d;
      irq_q  <= irq_d;
    end
  end

  assign irq_o = irq_q;

endmodule

// File: rtl/can_rxq_ovr_track.sv
module can_rxq_ovr_track
  import can_rxq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  rxq_evt_t evt_i,
  input  logic     clr_i,
  output logic     flag_o,
  output logic     irq_o
);

  logic flag_q, flag_d, irq_q, irq_d;

  always_comb begin
    flag_d = flag_q;
    if (evt_i.drop)  flag_d = 1'b1;
    else if (clr_i)  flag_d = 1'b0;
    irq_d = evt_i.drop && !flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      irq_q  <= irq_d;
    end
  end

  assign flag_o = flag_q;
  assign irq_o  = irq_q;

endmodule

// File: rtl/can_rxq_release.sv
module can_rxq_release
  import can_rxq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 2,
  parameter int GAP    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_push,
  input  logic [DATA_W-1:0] rx_frame,
  input  logic              rel_cmd,
  input  logic              clr_ovr_cmd,
  output logic [DATA_W-1:0] head_frame,
  output logic              rbuf_avail,
  output logic              ovr_status,
  output logic              rx_irq,
  output logic              ovr_irq
);

  logic     rst_q_n;
  rxq_evt_t evt;

  can_rxq_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  can_rxq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .push_i    (rx_push),
    .data_i    (rx_frame),
    .pop_req_i (rel_cmd),
    .head_o    (head_frame),
    .avail_o   (rbuf_avail),
    .evt_o     (evt)
  );

  can_rxq_irq_pacer #(.GAP(GAP)) u_pacer (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .pop_i   (evt.pop),
    .avail_i (rbuf_avail),
    .irq_o   (rx_irq)
  );

  can_rxq_ovr_track u_ovr (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .evt_i  (evt),
    .clr_i  (clr_ovr_cmd),
    .flag_o (ovr_status),
    .irq_o  (ovr_irq)
  );

endmodule

// File: rtl/can_rxq_release_chk.sv
module can_rxq_release_chk #(
  parameter int DATA_W = 32,
  parameter int GAP    = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_push,
  input logic              rel_cmd,
  input logic              clr_ovr_cmd,
  input logic [DATA_W-1:0] head_frame,
  input logic              rbuf_avail,
  input logic              ovr_status,
  input logic              rx_irq,
  input logic              ovr_irq
);

  localparam int SW = $clog2(GAP + 2) + 1;

  // Edges since the last accepted release, saturating above GAP
  logic [SW-1:0] since_rel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           since_rel_q <= SW'(GAP + 1);
    else if (rel_cmd && rbuf_avail)       since_rel_q <= '0;
    else if (since_rel_q != SW'(GAP + 1)) since_rel_q <= since_rel_q + 1'b1;
  end

  assert_head_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rbuf_avail && !rel_cmd) |=> $stable(head_frame));

  assert_empty_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!rbuf_avail && rel_cmd && !rx_push) |=> !rbuf_avail);

  assert_irq_needs_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> rbuf_avail);

  assert_irq_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> (since_rel_q > SW'(GAP)));

  assert_ovr_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_status) |-> $past(rx_push && !rel_cmd && rbuf_avail));

  assert_ovr_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ovr_status) |-> $past(clr_ovr_cmd));

  assert_ovr_irq_edge_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_irq |-> (ovr_status && !$past(ovr_status)));

endmodule

bind can_rxq_release can_rxq_release_chk #(.DATA_W(DATA_W), .GAP(GAP)) u_chk (
  .clk         (clk),
  .rst_n       (rst_q_n),
  .rx_push     (rx_push),
  .rel_cmd     (rel_cmd),
  .clr_ovr_cmd (clr_ovr_cmd),
  .head_frame  (head_frame),
  .rbuf_avail  (rbuf_avail),
  .ovr_status  (ovr_status),
  .rx_irq      (rx_irq),
  .ovr_irq     (ovr_irq)
);

// File: tb/tb_can_rxq_release.sv
module tb_can_rxq_release;

  localparam int DW = 32;

  logic          clk, rst_n, rx_push, rel_cmd, clr_ovr_cmd;
  logic [DW-1:0] rx_frame, head_frame;
  logic          rbuf_avail, ovr_status, rx_irq, ovr_irq;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  can_rxq_release #(.DATA_W(DW), .DEPTH(2), .GAP(2)) dut (
    .clk(clk), .rst_n(rst_n), .rx_push(rx_push), .rx_frame(rx_frame),
    .rel_cmd(rel_cmd), .clr_ovr_cmd(clr_ovr_cmd), .head_frame(head_frame),
    .rbuf_avail(rbuf_avail), .ovr_status(ovr_status), .rx_irq(rx_irq),
    .ovr_irq(ovr_irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One command cycle: drive after a falling edge, return at the next one
  task automatic step(input logic p, input logic [DW-1:0] d, input logic r, input logic c);
    rx_push = p; rx_frame = d; rel_cmd = r; clr_ovr_cmd = c;
    @(negedge clk);
    rx_push = 1'b0; rx_frame = '0; rel_cmd = 1'b0; clr_ovr_cmd = 1'b0;
  endtask

  task automatic idle();
    step(1'b0, '0, 1'b0, 1'b0);
  endtask

  task automatic t_reset();
    rx_push = 0; rx_frame = '0; rel_cmd = 0; clr_ovr_cmd = 0; rst_n = 0;
    repeat (3) @(negedge clk);
    chk("R11 avail in reset", {31'b0, rbuf_avail}, 0);
    chk("R11 head in reset", head_frame, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R11 outputs after reset", {27'b0, rbuf_avail, ovr_status, rx_irq, ovr_irq, 1'b0}, 0);
  endtask

  task automatic t_fill();
    step(1, 32'hAAAA_0001, 0, 0);
    chk("R2 avail after push", {31'b0, rbuf_avail}, 1);
    chk("R1 head first frame", head_frame, 32'hAAAA_0001);
    chk("R5 irq not yet", {31'b0, rx_irq}, 0);
    idle();
    chk("R5 irq one edge later", {31'b0, rx_irq}, 1);
    step(1, 32'hBBBB_0002, 0, 0);
    chk("R1 head keeps oldest", head_frame, 32'hAAAA_0001);
  endtask

  task automatic t_release_pacing();
    step(0, '0, 1, 0);
    chk("R3 next frame at once", head_frame, 32'hBBBB_0002);
    chk("R6 irq low on release", {31'b0, rx_irq}, 0);
    idle();
    chk("R6 irq low gap 1", {31'b0, rx_irq}, 0);
    idle();
    chk("R6 irq low gap 2", {31'b0, rx_irq}, 0);
    idle();
    chk("R6 irq back after gap", {31'b0, rx_irq}, 1);
    step(0, '0, 1, 0);
    chk("R3 empty after last release", {31'b0, rbuf_avail}, 0);
    chk("R1 head zero when empty", head_frame, 0);
  endtask

  task automatic t_empty_release();
    repeat (3) idle();
    step(0, '0, 1, 0);
    chk("R4 avail unchanged", {31'b0, rbuf_avail}, 0);
    chk("R4 head unchanged", head_frame, 0);
    chk("R4 flags unchanged", {29'b0, rx_irq, ovr_status, ovr_irq}, 0);
    step(1, 32'hCCCC_0003, 0, 0);
    idle();
    chk("R4 no pacing started", {31'b0, rx_irq}, 1);
  endtask

  task automatic t_overrun();
    step(1, 32'hDDDD_0004, 0, 0);
    chk("R7 no overrun while room", {31'b0, ovr_status}, 0);
    step(1, 32'hEEEE_0005, 0, 0);
    chk("R7 overrun set", {31'b0, ovr_status}, 1);
    chk("R10 overrun pulse", {31'b0, ovr_irq}, 1);
    idle();
    chk("R10 pulse one cycle", {31'b0, ovr_irq}, 0);
    step(1, 32'hFFFF_0006, 0, 0);
    chk("R10 suppressed while set", {31'b0, ovr_irq}, 0);
    chk("R7 head untouched", head_frame, 32'hCCCC_0003);
    step(0, '0, 1, 0);
    chk("R7 dropped frames absent", head_frame, 32'hDDDD_0004);
    step(0, '0, 1, 0);
    chk("R7 queue empties", {31'b0, rbuf_avail}, 0);
  endtask

  task automatic t_clear();
    step(0, '0, 0, 1);
    chk("R9 clear", {31'b0, ovr_status}, 0);
    step(1, 32'h1111_0007, 0, 0);
    step(1, 32'h2222_0008, 0, 0);
    step(1, 32'h3333_0009, 0, 1);
    chk("R9 set wins over clear", {31'b0, ovr_status}, 1);
    chk("R10 pulse after clear", {31'b0, ovr_irq}, 1);
    step(0, '0, 0, 1);
    chk("R9 clear again", {31'b0, ovr_status}, 0);
  endtask

  task automatic t_push_and_release();
    step(1, 32'h4444_000A, 1, 0);
    chk("R8 no overrun", {31'b0, ovr_status}, 0);
    chk("R8 head advanced", head_frame, 32'h2222_0008);
    step(0, '0, 1, 0);
    chk("R8 new frame stored", head_frame, 32'h4444_000A);
    step(0, '0, 1, 0);
    chk("R8 queue drained", {31'b0, rbuf_avail}, 0);
  endtask

  initial begin
    t_reset();
    t_fill();
    t_release_pacing();
    t_empty_release();
    t_overrun();
    t_clear();
    t_push_and_release();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule